// File: doc/BRIEF.md
# Capability Access Permission Checker

This block authorises each memory access made through a capability register. It sits between address generation and the memory stage. Every cycle it takes an uncompressed capability and an access request. The capability carries a validity tag, a lower bound, an upper bound, a cursor, permission bits and an object type. The request carries an access kind, a byte offset and a byte count. One cycle later the block reports whether the access may proceed, the effective address it targets, and a cause code.

The check does not look up a page table. It judges the access only from the state the pointer itself carries. When several problems are present at once, the block reports only the one with the highest priority. The cursor may wander outside the capability's range; only the effective address of an actual access is judged. The upper bound is one bit wider than an address, so a capability can cover the whole address space.

Top module: `cap_access_chk`

## Requirements
- R1: All outputs are registered and reflect the request presented one clock earlier. While the synchronous active-high reset is asserted, the outputs are pass = 0, cause = 0 and effective address = 0.
- R2: The effective address is the cursor plus the offset, taken modulo 2^ADDR_W, so a two's-complement offset can move the address downwards.
- R3: A capability whose tag is 0 is refused with cause 1. This outranks every other violation.
- R4: A tagged capability is sealed when its object type differs from the all-ones value. A sealed capability is refused with cause 2. This outranks the permission and length violations.
- R5: The access kind selects one permission bit. Kind 0 (load) needs perm bit 0, kind 1 (store) needs perm bit 1, and kind 2 (fetch) needs perm bit 2. Kind 3 never has a permission. A missing permission gives cause 3, which outranks the length violation.
- R6: The access passes the bounds test only when base <= address and address + size <= top. The sum is formed at ADDR_W+1 bits, so it cannot wrap. Otherwise the cause is 4.
- R7: A cursor that lies outside the bounds raises no error when the effective address and size fall inside them.
- R8: Pass is 1 exactly when the cause is 0 (none). The cause is never above 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_tag | input | 1 | Capability validity tag |
| cap_base | input | ADDR_W | Lowest byte address the capability grants |
| cap_top | input | ADDR_W+1 | One past the highest granted byte |
| cap_cursor | input | ADDR_W | Current pointer value |
| cap_perms | input | PERM_W | Permission bits (0 load, 1 store, 2 fetch) |
| cap_otype | input | OTYPE_W | Object type; all ones means unsealed |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| acc_offset | input | ADDR_W | Offset added to the cursor |
| acc_size | input | SIZE_W | Access length in bytes |
| chk_pass | output | 1 | Access allowed |
| chk_addr | output | ADDR_W | Registered effective address |
| chk_cause | output | 3 | 0 none, 1 tag, 2 seal, 3 permission, 4 length |

## Verification
On every cycle, the assertions check four relations:
- pass and cause agree;
- the cause stays inside its range;
- a cleared tag or a sealed object type yields its own cause;
- the effective address follows the previous request.

The permission and bounds outcomes have some relations the assertions do not cover. These are the ordering between permission and length faults, the exact-fit and one-byte-over edges, the carry into the extra top bit, and a cursor outside the bounds with an in-range offset. Only the directed scenarios show these.

// File: rtl/cap_chk_pkg.sv
package cap_chk_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_TAG  = 3'd1,
    CAUSE_SEAL = 3'd2,
    CAUSE_PERM = 3'd3,
    CAUSE_LEN  = 3'd4
  } cause_e;
endpackage

// File: rtl/cap_bounds_cmp.sv
module cap_bounds_cmp #(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 5
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W:0]   top,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              in_bounds
);
  localparam int PAD_W = ADDR_W + 1 - SIZE_W;

  logic [ADDR_W:0] end_addr;
  logic            lo_ok;
  logic            hi_ok;

  // one extra bit keeps the end address from wrapping
  always_comb begin
    end_addr  = {1'b0, addr} + {{PAD_W{1'b0}}, size};
    lo_ok     = (addr >= base);
    hi_ok     = (end_addr <= top);
    in_bounds = lo_ok && hi_ok;
  end
endmodule

// File: rtl/cap_perm_sel.sv
module cap_perm_sel
  import cap_chk_pkg::*;
#(
  parameter int PERM_W  = 3,
  parameter int OTYPE_W = 18,
  parameter int LD_IDX  = 0,
  parameter int ST_IDX  = 1,
  parameter int EX_IDX  = 2
) (
  input  logic [PERM_W-1:0]  perms,
  input  logic [OTYPE_W-1:0] otype,
  input  acc_kind_e          kind,
  output logic               sealed,
  output logic               perm_ok
);
  localparam logic [OTYPE_W-1:0] UNSEALED = '1;

  always_comb begin
    sealed = (otype != UNSEALED);
    unique case (kind)
      ACC_LOAD:  perm_ok = perms[LD_IDX];
      ACC_STORE: perm_ok = perms[ST_IDX];
      ACC_FETCH: perm_ok = perms[EX_IDX];
      default:   perm_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_cause_enc.sv
module cap_cause_enc
  import cap_chk_pkg::*;
(
  input  logic   tag_ok,
  input  logic   sealed,
  input  logic   perm_ok,
  input  logic   in_bounds,
  output cause_e cause
);
  // fixed priority: tag, seal, permission, length
  always_comb begin
    if (!tag_ok)         cause = CAUSE_TAG;
    else if (sealed)     cause = CAUSE_SEAL;
    else if (!perm_ok)   cause = CAUSE_PERM;
    else if (!in_bounds) cause = CAUSE_LEN;
    else                 cause = CAUSE_NONE;
  end
endmodule

// File: rtl/cap_access_chk.sv
module cap_access_chk
  import cap_chk_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int PERM_W  = 3,
  parameter int OTYPE_W = 18,
  parameter int SIZE_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_tag,
  input  logic [ADDR_W-1:0]  cap_base,
  input  logic [ADDR_W:0]    cap_top,
  input  logic [ADDR_W-1:0]  cap_cursor,
  input  logic [PERM_W-1:0]  cap_perms,
  input  logic [OTYPE_W-1:0] cap_otype,
  input  logic [1:0]         acc_kind,
  input  logic [ADDR_W-1:0]  acc_offset,
  input  logic [SIZE_W-1:0]  acc_size,
  output logic               chk_pass,
  output logic [ADDR_W-1:0]  chk_addr,
  output logic [2:0]         chk_cause
);
  logic [ADDR_W-1:0] eff_addr;
  logic              sealed;
  logic              perm_ok;
  logic              in_bounds;
  cause_e            cause_d;

  assign eff_addr = cap_cursor + acc_offset;

  cap_perm_sel #(
    .PERM_W (PERM_W),
    .OTYPE_W(OTYPE_W)
  ) u_perm (
    .perms  (cap_perms),
    .otype  (cap_otype),
    .kind   (acc_kind_e'(acc_kind)),
    .sealed (sealed),
    .perm_ok(perm_ok)
  );

  cap_bounds_cmp #(
    .ADDR_W(ADDR_W),
    .SIZE_W(SIZE_W)
  ) u_bounds (
    .base     (cap_base),
    .top      (cap_top),
    .addr     (eff_addr),
    .size     (acc_size),
    .in_bounds(in_bounds)
  );

  cap_cause_enc u_cause (
    .tag_ok   (cap_tag),
    .sealed   (sealed),
    .perm_ok  (perm_ok),
    .in_bounds(in_bounds),
    .cause    (cause_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_pass  <= 1'b0;
      chk_addr  <= '0;
      chk_cause <= CAUSE_NONE;
    end else begin
      chk_pass  <= (cause_d == CAUSE_NONE);
      chk_addr  <= eff_addr;
      chk_cause <= cause_d;
    end
  end
endmodule

// File: rtl/cap_access_chk_sva.sv
module cap_access_chk_sva #(
  parameter int ADDR_W  = 64,
  parameter int OTYPE_W = 18
) (
  input logic               clk,
  input logic               rst,
  input logic               cap_tag,
  input logic [OTYPE_W-1:0] cap_otype,
  input logic [ADDR_W-1:0]  cap_cursor,
  input logic [ADDR_W-1:0]  acc_offset,
  input logic               chk_pass,
  input logic [ADDR_W-1:0]  chk_addr,
  input logic [2:0]         chk_cause
);
  localparam logic [OTYPE_W-1:0] ALL_ONES = '1;

  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  // R3
  tag_first_chk: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(cap_tag) |-> (chk_cause == 3'd1) && !chk_pass);

  // R4
  seal_second_chk: assert property (@(posedge clk) disable iff (rst)
    primed && $past(cap_tag) && ($past(cap_otype) != ALL_ONES) |-> (chk_cause == 3'd2));

  // R8
  pass_clean_chk: assert property (@(posedge clk) disable iff (rst)
    chk_pass |-> (chk_cause == 3'd0));

  // R8
  refuse_coded_chk: assert property (@(posedge clk) disable iff (rst)
    primed && !chk_pass |-> (chk_cause != 3'd0) && (chk_cause <= 3'd4));

  // R2
  addr_follow_chk: assert property (@(posedge clk) disable iff (rst)
    primed |-> chk_addr == $past(cap_cursor + acc_offset));
endmodule

bind cap_access_chk cap_access_chk_sva #(
  .ADDR_W (ADDR_W),
  .OTYPE_W(OTYPE_W)
) u_sva (
  .clk       (clk),
  .rst       (rst),
  .cap_tag   (cap_tag),
  .cap_otype (cap_otype),
  .cap_cursor(cap_cursor),
  .acc_offset(acc_offset),
  .chk_pass  (chk_pass),
  .chk_addr  (chk_addr),
  .chk_cause (chk_cause)
);

// File: tb/cap_access_chk_tb.sv
module cap_access_chk_tb;
  localparam int ADDR_W  = 64;
  localparam int PERM_W  = 3;
  localparam int OTYPE_W = 18;
  localparam int SIZE_W  = 5;
  localparam logic [OTYPE_W-1:0] UNSEALED = '1;
  localparam logic [OTYPE_W-1:0] SEALED_T = 18'h5;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cap_tag = 1'b0;
  logic [ADDR_W-1:0]  cap_base = '0;
  logic [ADDR_W:0]    cap_top = '0;
  logic [ADDR_W-1:0]  cap_cursor = '0;
  logic [PERM_W-1:0]  cap_perms = '0;
  logic [OTYPE_W-1:0] cap_otype = '1;
  logic [1:0]         acc_kind = '0;
  logic [ADDR_W-1:0]  acc_offset = '0;
  logic [SIZE_W-1:0]  acc_size = '0;
  logic               chk_pass;
  logic [ADDR_W-1:0]  chk_addr;
  logic [2:0]         chk_cause;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cap_access_chk #(
    .ADDR_W(ADDR_W), .PERM_W(PERM_W), .OTYPE_W(OTYPE_W), .SIZE_W(SIZE_W)
  ) u_dut (
    .clk(clk), .rst(rst), .cap_tag(cap_tag), .cap_base(cap_base),
    .cap_top(cap_top), .cap_cursor(cap_cursor), .cap_perms(cap_perms),
    .cap_otype(cap_otype), .acc_kind(acc_kind), .acc_offset(acc_offset),
    .acc_size(acc_size), .chk_pass(chk_pass), .chk_addr(chk_addr),
    .chk_cause(chk_cause)
  );

  task automatic expect_out(string req, logic p, logic [2:0] c, logic [ADDR_W-1:0] a);
    n_run++;
    if (chk_pass !== p || chk_cause !== c || chk_addr !== a) begin
      n_fail++;
      $display("FAIL %s: pass=%0b cause=%0d addr=%h, expected pass=%0b cause=%0d addr=%h",
               req, chk_pass, chk_cause, chk_addr, p, c, a);
    end
  endtask

  // drive on the falling edge, result registered at the next rising edge
  task automatic run(string req, logic tag, logic [ADDR_W-1:0] base, logic [ADDR_W:0] top,
                     logic [ADDR_W-1:0] cur, logic [ADDR_W-1:0] off, logic [SIZE_W-1:0] sz,
                     logic [PERM_W-1:0] pm, logic [OTYPE_W-1:0] ot, logic [1:0] kind,
                     logic p, logic [2:0] c, logic [ADDR_W-1:0] a);
    @(negedge clk);
    cap_tag = tag; cap_base = base; cap_top = top; cap_cursor = cur;
    acc_offset = off; acc_size = sz; cap_perms = pm; cap_otype = ot; acc_kind = kind;
    @(posedge clk);
    @(negedge clk);
    expect_out(req, p, c, a);
  endtask

  task automatic t_reset();
    // R1: reset values while rst is high, with a request that would pass
    @(negedge clk);
    cap_tag = 1'b1; cap_base = 64'h1000; cap_top = 65'h2000; cap_cursor = 64'h1000;
    cap_perms = 3'b111; cap_otype = UNSEALED; acc_size = 5'd4;
    @(posedge clk);
    @(negedge clk);
    expect_out("R1 reset", 1'b0, 3'd0, 64'h0);
    rst = 1'b0;
  endtask

  task automatic t_load_ok();
    // R2 R6 R8: ordinary load inside bounds
    run("R2 load ok", 1'b1, 64'h1000, 65'h2000, 64'h1000, 64'h10, 5'd8, 3'b001, UNSEALED, 2'd0,
        1'b1, 3'd0, 64'h1010);
  endtask

  task automatic t_perm_kinds();
    run("R5 store no perm", 1'b1, 64'h1000, 65'h2000, 64'h1100, 64'h0, 5'd4, 3'b001, UNSEALED, 2'd1,
        1'b0, 3'd3, 64'h1100);
    run("R5 store ok", 1'b1, 64'h1000, 65'h2000, 64'h1100, 64'h0, 5'd4, 3'b010, UNSEALED, 2'd1,
        1'b1, 3'd0, 64'h1100);
    run("R5 fetch ok", 1'b1, 64'h1000, 65'h2000, 64'h1200, 64'h0, 5'd4, 3'b100, UNSEALED, 2'd2,
        1'b1, 3'd0, 64'h1200);
    run("R5 fetch no perm", 1'b1, 64'h1000, 65'h2000, 64'h1200, 64'h0, 5'd4, 3'b011, UNSEALED, 2'd2,
        1'b0, 3'd3, 64'h1200);
    run("R5 reserved kind", 1'b1, 64'h1000, 65'h2000, 64'h1200, 64'h0, 5'd4, 3'b111, UNSEALED, 2'd3,
        1'b0, 3'd3, 64'h1200);
  endtask

  task automatic t_priority();
    run("R3 tag over all", 1'b0, 64'h1000, 65'h2000, 64'h9000, 64'h8, 5'd8, 3'b000, SEALED_T, 2'd0,
        1'b0, 3'd1, 64'h9008);
    run("R4 seal over perm+len", 1'b1, 64'h1000, 65'h2000, 64'h9000, 64'h0, 5'd8, 3'b000, SEALED_T, 2'd0,
        1'b0, 3'd2, 64'h9000);
    run("R4 seal in bounds", 1'b1, 64'h1000, 65'h2000, 64'h1000, 64'h0, 5'd8, 3'b111, SEALED_T, 2'd0,
        1'b0, 3'd2, 64'h1000);
    run("R5 perm over len", 1'b1, 64'h1000, 65'h2000, 64'h9000, 64'h0, 5'd8, 3'b001, UNSEALED, 2'd1,
        1'b0, 3'd3, 64'h9000);
  endtask

  task automatic t_bounds_edges();
    run("R6 exact fit", 1'b1, 64'h1000, 65'h2000, 64'h1FF8, 64'h0, 5'd8, 3'b001, UNSEALED, 2'd0,
        1'b1, 3'd0, 64'h1FF8);
    run("R6 one over", 1'b1, 64'h1000, 65'h2000, 64'h1FF9, 64'h0, 5'd8, 3'b001, UNSEALED, 2'd0,
        1'b0, 3'd4, 64'h1FF9);
    run("R6 below base", 1'b1, 64'h1000, 65'h2000, 64'h0FFF, 64'h0, 5'd1, 3'b001, UNSEALED, 2'd0,
        1'b0, 3'd4, 64'h0FFF);
    run("R6 size zero at top", 1'b1, 64'h1000, 65'h2000, 64'h2000, 64'h0, 5'd0, 3'b001, UNSEALED, 2'd0,
        1'b1, 3'd0, 64'h2000);
  endtask

  task automatic t_cursor_outside();
    // R7 R2: cursor beyond top, negative offset brings the access back to base
    run("R7 cursor outside", 1'b1, 64'h1000, 65'h2000, 64'h5000, 64'hFFFF_FFFF_FFFF_C000, 5'd8,
        3'b001, UNSEALED, 2'd0, 1'b1, 3'd0, 64'h1000);
  endtask

  task automatic t_wide_top();
    // R6: the end address carries into the extra bit and must not wrap
    run("R6 full top fit", 1'b1, 64'hFFFF_FFFF_FFFF_FF00, 65'h1_0000_0000_0000_0000,
        64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 5'd4, 3'b001, UNSEALED, 2'd0, 1'b1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFC);
    run("R6 full top wrap", 1'b1, 64'hFFFF_FFFF_FFFF_FF00, 65'h1_0000_0000_0000_0000,
        64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 5'd8, 3'b001, UNSEALED, 2'd0, 1'b0, 3'd4, 64'hFFFF_FFFF_FFFF_FFFC);
  endtask

  initial begin
    t_reset();
    t_load_ok();
    t_perm_kinds();
    t_priority();
    t_bounds_edges();
    t_cursor_outside();
    t_wide_top();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: done=0, expected done=1");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule